// File: doc/BRIEF.md
# Receive Ring Buffer Manager

This block takes received Ethernet frames as a byte stream and stores them in a circular region of a byte-wide packet memory. The memory is divided into 256-byte pages. The host programs four page numbers: the first page of the ring, the page just past its end, the page where the next frame will be written (the write page), and the page the host has not yet consumed (the read limit). Each frame is stored one page boundary at a time. A 4-byte descriptor comes first, holding the receive status, the page of the following frame and the stored length. The frame bytes follow, and they wrap from the end of the ring back to its first page.

When a frame's first byte arrives, the block decides whether to take it. If the receiver is halted, or the ring does not have room for a worst-case frame, the whole frame is drained and discarded. In that case nothing is written and a one-cycle drop pulse is given. Accepted frames shorter than the Ethernet minimum are padded with zeros. Once the descriptor is written, the write page moves to the next frame's page and a receive interrupt flag is set, which the host later clears.

Frame input is a valid/ready stream with a last marker. A beat transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high while the block waits for a frame, while it copies frame bytes, and while it drains a refused frame. It drops low while padding and descriptor bytes are written, which takes one cycle per byte. The sender must hold data, valid and last stable until the beat is taken. The memory port is write-only and has no back-pressure.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset the write page reads 0, the interrupt flag is low and `in_ready` is high. The ring bounds reset to 0, so the ring counts as full: a frame is dropped, `drop_pulse` is high the cycle after its last beat, and no memory write occurs.
- R2: The ring is full when the end page is not above the first page, or when the free bytes are below 1518. Free bytes are counted with byte address = page × 256. If the write page is below the read limit, free bytes = (read limit − write page) × 256. Otherwise free bytes = ring size − (write page − read limit) × 256. A frame arriving while the ring is full is dropped.
- R3: A frame arriving while `rx_halt` is high is dropped.
- R4: A dropped frame is accepted beat by beat with `in_ready` high. It causes no memory write and no change to the write page or the interrupt flag. `drop_pulse` is high for exactly the cycle after its last beat.
- R5: An accepted frame shorter than 60 bytes is followed in memory by zero bytes until 60 data bytes are stored. Longer frames get no padding.
- R6: With base = write page × 256 at frame start, the descriptor goes to base+0..base+3 and frame byte k goes to base+4+k. The stored length L = max(frame bytes, 60) + 4 is written low byte at base+2 and high byte at base+3. An accepted frame produces exactly L memory writes.
- R7: The next-frame page = write page + ceil((L+4)/256). If that is greater than or equal to the end page, the ring size in pages is subtracted. This page is written at base+1.
- R8: A data byte whose address would reach end page × 256 is written at first page × 256 instead, and the following bytes continue from there.
- R9: The status byte at base+0 is 0x01, or 0x21 when bit 0 of the frame's first byte is set.
- R10: When the descriptor is complete, `rx_irq` goes high on the same edge that the write page takes the next-frame page. A high `irq_clr` clears the flag on the next edge, but a completion in that same cycle wins and the flag stays high.
- R11: A host write to the write page in the same cycle as a frame completion is lost. The write page takes the next-frame page.
- R12: `in_ready` is low while padding or descriptor bytes are being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Host page register write strobe |
| cfg_sel | input | 2 | Register select: 0 first page, 1 end page, 2 read limit, 3 write page |
| cfg_wdata | input | 8 | Page number to write |
| rx_halt | input | 1 | Receiver halted; frames are refused |
| irq_clr | input | 1 | Clears the receive interrupt flag |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_ready | output | 1 | Block can take a frame byte |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| wr_page | output | 8 | Current write page |
| rx_irq | output | 1 | Receive interrupt flag |
| drop_pulse | output | 1 | One-cycle pulse after a refused frame's last beat |

## Verification
Frame completion shares a cycle with two host actions. It updates the write page, which the host may be writing in the same cycle. It also sets the interrupt flag, which the host may be clearing in the same cycle. The bench provokes both at once: it holds `irq_clr` high and a host write of an unrelated page steady from just after a short frame's last beat until the flag is seen. The flag must rise anyway, and the write page must read the computed next-frame page rather than the host value. It must still read that page once both host inputs are released.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STORE,
    ST_PAD,
    ST_HDR,
    ST_DROP
  } rxr_state_e;

  localparam logic [1:0] SEL_FIRST = 2'd0;
  localparam logic [1:0] SEL_END   = 2'd1;
  localparam logic [1:0] SEL_LIMIT = 2'd2;
  localparam logic [1:0] SEL_WRPG  = 2'd3;

  localparam int unsigned DESC_BYTES = 4;
  localparam logic [7:0]  STAT_GOOD  = 8'h01;
  localparam logic [7:0]  STAT_GROUP = 8'h20;
endpackage

// File: rtl/rxr_page_regs.sv
module rxr_page_regs
  import rxr_pkg::*;
#(
  parameter int unsigned PG_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [PG_W-1:0] cfg_wdata,
  input  logic            hw_done,
  input  logic [PG_W-1:0] hw_next,
  input  logic            irq_clr,
  output logic [PG_W-1:0] first_pg,
  output logic [PG_W-1:0] end_pg,
  output logic [PG_W-1:0] limit_pg,
  output logic [PG_W-1:0] wr_pg,
  output logic            irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_pg <= '0;
      end_pg   <= '0;
      limit_pg <= '0;
      wr_pg    <= '0;
      irq      <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          SEL_FIRST: first_pg <= cfg_wdata;
          SEL_END:   end_pg   <= cfg_wdata;
          SEL_LIMIT: limit_pg <= cfg_wdata;
          default:   wr_pg    <= cfg_wdata;
        endcase
      end
      // hardware completion has priority over the host
      if (hw_done) wr_pg <= hw_next;
      if (hw_done)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  // R10
  irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_done |=> irq);

  // R11
  wrpg_hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_done |=> (wr_pg == $past(hw_next)));

endmodule

// File: rtl/rxr_space_chk.sv
module rxr_space_chk #(
  parameter int unsigned PG_W      = 8,
  parameter int unsigned PG_SH     = 8,
  parameter int unsigned MAX_FRAME = 1514,
  parameter int unsigned SLACK     = 4
) (
  input  logic [PG_W-1:0] first_pg,
  input  logic [PG_W-1:0] end_pg,
  input  logic [PG_W-1:0] wr_pg,
  input  logic [PG_W-1:0] limit_pg,
  output logic            ring_full
);
  localparam int unsigned AW   = PG_W + PG_SH + 1;
  localparam int unsigned NEED = MAX_FRAME + SLACK;

  logic [AW-1:0] idx, lim, span, avail;

  always_comb begin
    idx  = AW'(wr_pg) << PG_SH;
    lim  = AW'(limit_pg) << PG_SH;
    span = (AW'(end_pg) - AW'(first_pg)) << PG_SH;
    if (idx < lim) avail = lim - idx;
    else           avail = span - (idx - lim);
    ring_full = (end_pg <= first_pg) || (avail < AW'(NEED));
  end
endmodule

// File: rtl/rxr_next_calc.sv
module rxr_next_calc #(
  parameter int unsigned PG_W  = 8,
  parameter int unsigned PG_SH = 8,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned DESC  = 4
) (
  input  logic [PG_W-1:0]  base_pg,
  input  logic [LEN_W-1:0] data_len,
  input  logic [PG_W-1:0]  first_pg,
  input  logic [PG_W-1:0]  end_pg,
  output logic [PG_W-1:0]  next_pg
);
  localparam int unsigned NW    = LEN_W + 2;
  localparam int unsigned PG_SZ = 1 << PG_SH;

  logic [NW-1:0] pages, sum, ring, nx;

  always_comb begin
    // stored length plus descriptor plus trailing slack, rounded to pages
    pages = (NW'(data_len) + NW'(2 * DESC) + NW'(PG_SZ - 1)) >> PG_SH;
    sum   = NW'(base_pg) + pages;
    ring  = NW'(end_pg) - NW'(first_pg);
    nx    = (sum >= NW'(end_pg)) ? (sum - ring) : sum;
    next_pg = nx[PG_W-1:0];
  end
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
  import rxr_pkg::*;
#(
  parameter int unsigned PG_W      = 8,
  parameter int unsigned PG_SH     = 8,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MAX_FRAME = 1514,
  parameter int unsigned MIN_FRAME = 60
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_sel,
  input  logic [PG_W-1:0]       cfg_wdata,
  input  logic                  rx_halt,
  input  logic                  irq_clr,
  input  logic                  in_valid,
  input  logic [7:0]            in_data,
  input  logic                  in_last,
  output logic                  in_ready,
  output logic                  mem_we,
  output logic [PG_W+PG_SH-1:0] mem_addr,
  output logic [7:0]            mem_wdata,
  output logic [PG_W-1:0]       wr_page,
  output logic                  rx_irq,
  output logic                  drop_pulse
);
  localparam int unsigned AW = PG_W + PG_SH;

  logic [PG_W-1:0]  first_pg, end_pg, limit_pg, wr_pg, base_pg, next_pg;
  logic             ring_full, done, accept, beat, grp;
  logic [AW-1:0]    wptr, ring_lo, ring_hi, first_addr;
  logic [LEN_W-1:0] cnt, cnt_nx, total;
  logic [1:0]       hidx;
  logic [7:0]       desc_byte;
  rxr_state_e       st;

  rxr_page_regs #(.PG_W(PG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .hw_done(done), .hw_next(next_pg),
    .irq_clr(irq_clr), .first_pg(first_pg), .end_pg(end_pg),
    .limit_pg(limit_pg), .wr_pg(wr_pg), .irq(rx_irq)
  );

  rxr_space_chk #(.PG_W(PG_W), .PG_SH(PG_SH), .MAX_FRAME(MAX_FRAME),
                  .SLACK(DESC_BYTES)) u_space (
    .first_pg(first_pg), .end_pg(end_pg), .wr_pg(wr_pg),
    .limit_pg(limit_pg), .ring_full(ring_full)
  );

  rxr_next_calc #(.PG_W(PG_W), .PG_SH(PG_SH), .LEN_W(LEN_W),
                  .DESC(DESC_BYTES)) u_next (
    .base_pg(base_pg), .data_len(cnt), .first_pg(first_pg),
    .end_pg(end_pg), .next_pg(next_pg)
  );

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p,
                                         input logic [AW-1:0] lo,
                                         input logic [AW-1:0] hi);
    logic [AW-1:0] n;
    n = p + AW'(1);
    return (n == hi) ? lo : n;
  endfunction

  assign wr_page    = wr_pg;
  assign ring_lo    = AW'(first_pg) << PG_SH;
  assign ring_hi    = AW'(end_pg) << PG_SH;
  assign first_addr = (AW'(wr_pg) << PG_SH) + AW'(DESC_BYTES);
  assign in_ready   = (st == ST_IDLE) || (st == ST_STORE) || (st == ST_DROP);
  assign beat       = in_valid && in_ready;
  assign accept     = !rx_halt && !ring_full;
  assign cnt_nx     = cnt + LEN_W'(1);
  assign total      = cnt + LEN_W'(DESC_BYTES);
  assign done       = (st == ST_HDR) && (hidx == 2'd3);

  always_comb begin
    case (hidx)
      2'd0:    desc_byte = STAT_GOOD | (grp ? STAT_GROUP : 8'h00);
      2'd1:    desc_byte = 8'(next_pg);
      2'd2:    desc_byte = total[7:0];
      default: desc_byte = total[15:8];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      wptr       <= '0;
      base_pg    <= '0;
      cnt        <= '0;
      grp        <= 1'b0;
      hidx       <= '0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      drop_pulse <= 1'b0;
    end else begin
      mem_we     <= 1'b0;
      drop_pulse <= 1'b0;
      case (st)
        ST_IDLE: if (beat) begin
          if (accept) begin
            mem_we    <= 1'b1;
            mem_addr  <= first_addr;
            mem_wdata <= in_data;
            wptr      <= step(first_addr, ring_lo, ring_hi);
            base_pg   <= wr_pg;
            cnt       <= LEN_W'(1);
            grp       <= in_data[0];
            hidx      <= '0;
            if (in_last) st <= (LEN_W'(1) >= LEN_W'(MIN_FRAME)) ? ST_HDR : ST_PAD;
            else         st <= ST_STORE;
          end else if (in_last) begin
            drop_pulse <= 1'b1;
          end else begin
            st <= ST_DROP;
          end
        end
        ST_STORE: if (beat) begin
          mem_we    <= 1'b1;
          mem_addr  <= wptr;
          mem_wdata <= in_data;
          wptr      <= step(wptr, ring_lo, ring_hi);
          cnt       <= cnt_nx;
          if (in_last) st <= (cnt_nx >= LEN_W'(MIN_FRAME)) ? ST_HDR : ST_PAD;
        end
        ST_PAD: begin
          mem_we    <= 1'b1;
          mem_addr  <= wptr;
          mem_wdata <= 8'h00;
          wptr      <= step(wptr, ring_lo, ring_hi);
          cnt       <= cnt_nx;
          if (cnt_nx >= LEN_W'(MIN_FRAME)) st <= ST_HDR;
        end
        ST_HDR: begin
          mem_we    <= 1'b1;
          mem_addr  <= (AW'(base_pg) << PG_SH) + AW'(hidx);
          mem_wdata <= desc_byte;
          hidx      <= hidx + 2'd1;
          if (hidx == 2'd3) st <= ST_IDLE;
        end
        ST_DROP: if (beat && in_last) begin
          drop_pulse <= 1'b1;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  addr_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= ring_lo) && (mem_addr < ring_hi));

  // R4
  drop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> !mem_we);

  // R7
  next_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (next_pg >= first_pg) && (next_pg < end_pg));

  // R12
  busy_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PAD) |=> !drop_pulse && mem_we);

endmodule

// File: tb/rx_ring_mgr_tb.sv
module rx_ring_mgr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        rx_halt = 1'b0;
  logic        irq_clr = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready, mem_we, rx_irq, drop_pulse;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, wr_page;

  int nchk = 0;
  int nfail = 0;
  int wr_count = 0;
  bit done_flag = 1'b0;
  logic [7:0] bmem [int];

  always #4 clk = ~clk;

  rx_ring_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rx_halt(rx_halt), .irq_clr(irq_clr),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .wr_page(wr_page), .rx_irq(rx_irq),
    .drop_pulse(drop_pulse)
  );

  always @(posedge clk) if (mem_we) begin
    bmem[int'(mem_addr)] = mem_wdata;
    wr_count++;
  end

  // len, first byte, start page, expected next page, expected status
  localparam logic [47:0] VEC [5] = '{
    {16'd10,  8'h01, 8'h40, 8'h41, 8'h21},
    {16'd300, 8'h02, 8'h41, 8'h43, 8'h01},
    {16'd60,  8'h00, 8'h43, 8'h44, 8'h01},
    {16'd253, 8'h03, 8'h44, 8'h46, 8'h21},
    {16'd248, 8'h00, 8'h46, 8'h47, 8'h01}
  };

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clr_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  // returns at the negedge after the last beat
  task automatic send(input int len, input logic [7:0] first);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = (i == 0) ? first : pat(i);
      in_last  = (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      if (rx_irq) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  function automatic int rd(input int a);
    return bmem.exists(a) ? int'(bmem[a]) : 'h1ff;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int base, wc, len, stored;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(wr_page == 8'h00, "R1 wr_page", wr_page, 0);
    chk(rx_irq == 1'b0, "R1 irq", rx_irq, 0);
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
    wc = wr_count;
    send(70, 8'h10);
    chk(drop_pulse == 1'b1, "R1 drop on empty ring", drop_pulse, 1);
    chk(wr_count == wc, "R1 no writes", wr_count, wc);

    cfg(2'd0, 8'h40); cfg(2'd1, 8'h50); cfg(2'd2, 8'h40); cfg(2'd3, 8'h40);

    // R3 halted receiver
    rx_halt = 1'b1;
    wc = wr_count;
    send(20, 8'h00);
    chk(drop_pulse == 1'b1, "R3 drop when halted", drop_pulse, 1);
    @(negedge clk);
    chk(drop_pulse == 1'b0, "R4 drop is one cycle", drop_pulse, 0);
    chk(wr_count == wc, "R4 no writes on drop", wr_count, wc);
    chk(wr_page == 8'h40, "R4 page unchanged", wr_page, 'h40);
    chk(rx_irq == 1'b0, "R4 irq unchanged", rx_irq, 0);
    rx_halt = 1'b0;

    // vector table
    foreach (VEC[v]) begin
      len = int'(VEC[v][47:32]);
      stored = (len < 60) ? 60 : len;
      base = int'(VEC[v][23:16]) << 8;
      cfg(2'd3, VEC[v][23:16]);
      clr_irq();
      bmem.delete();
      wc = wr_count;
      send(len, VEC[v][31:24]);
      chk(drop_pulse == 1'b0, "R2 frame accepted", drop_pulse, 0);
      wait_irq(seen);
      chk(seen, "R10 irq raised", rx_irq, 1);
      chk(wr_page == VEC[v][15:8], "R7 next page", wr_page, VEC[v][15:8]);
      repeat (2) @(negedge clk);
      chk(rd(base) == int'(VEC[v][7:0]), "R9 status", rd(base), VEC[v][7:0]);
      chk(rd(base + 1) == int'(VEC[v][15:8]), "R7 next in descriptor", rd(base + 1), VEC[v][15:8]);
      chk(rd(base + 2) == ((stored + 4) & 255), "R6 length low", rd(base + 2), (stored + 4) & 255);
      chk(rd(base + 3) == ((stored + 4) >> 8), "R6 length high", rd(base + 3), (stored + 4) >> 8);
      chk(rd(base + 4) == int'(VEC[v][31:24]), "R6 first byte", rd(base + 4), VEC[v][31:24]);
      chk(rd(base + 3 + len) == int'(pat(len - 1)), "R6 last byte", rd(base + 3 + len), pat(len - 1));
      chk(wr_count - wc == stored + 4, "R6 write count", wr_count - wc, stored + 4);
      if (len < 60) begin
        chk(rd(base + 4 + len) == 0, "R5 pad first", rd(base + 4 + len), 0);
        chk(rd(base + 63) == 0, "R5 pad last", rd(base + 63), 0);
      end else begin
        chk(!bmem.exists(base + 4 + len), "R5 no pad", rd(base + 4 + len), 'h1ff);
      end
    end

    // R2 free space boundary: 1280 bytes refused, 1536 accepted
    cfg(2'd3, 8'h40); cfg(2'd2, 8'h45);
    clr_irq();
    wc = wr_count;
    send(10, 8'h00);
    chk(drop_pulse == 1'b1, "R2 refuse below 1518", drop_pulse, 1);
    chk(wr_count == wc, "R2 no writes when full", wr_count, wc);
    cfg(2'd2, 8'h46);
    send(10, 8'h00);
    chk(drop_pulse == 1'b0, "R2 accept at 1536", drop_pulse, 0);
    chk(in_ready == 1'b0, "R12 ready low while padding", in_ready, 0);
    wait_irq(seen);
    chk(wr_page == 8'h41, "R2 accepted frame page", wr_page, 'h41);

    // R8 payload wrap
    cfg(2'd3, 8'h4F);
    clr_irq();
    bmem.delete();
    send(300, 8'h02);
    wait_irq(seen);
    repeat (2) @(negedge clk);
    chk(wr_page == 8'h41, "R7 next page wraps", wr_page, 'h41);
    chk(rd('h4F01) == 'h41, "R7 wrapped next in descriptor", rd('h4F01), 'h41);
    chk(rd('h4FFF) == int'(pat(251)), "R8 byte before wrap", rd('h4FFF), pat(251));
    chk(rd('h4000) == int'(pat(252)), "R8 byte after wrap", rd('h4000), pat(252));
    chk(rd('h402F) == int'(pat(299)), "R8 last byte after wrap", rd('h402F), pat(299));
    chk(!bmem.exists('h5000), "R8 no write past end", rd('h5000), 'h1ff);

    // R10 / R11 collisions at frame completion
    cfg(2'd3, 8'h48);
    clr_irq();
    send(10, 8'h00);
    irq_clr = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 8'h4A;
    wait_irq(seen);
    chk(seen, "R10 set wins over clear", rx_irq, 1);
    chk(wr_page == 8'h49, "R11 hardware page wins", wr_page, 'h49);
    irq_clr = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    chk(wr_page == 8'h49, "R11 page after release", wr_page, 'h49);
    chk(rx_irq == 1'b1, "R10 flag held", rx_irq, 1);
    clr_irq();
    chk(rx_irq == 1'b0, "R10 clear", rx_irq, 0);

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule